// File: doc/BRIEF.md
# I2C Master Register and Interrupt File

This block is the bus-facing register file of a command-driven I2C master. It decodes a plain 32-bit register bus, keeps the control word, the SCL high and low period counts and the transmit byte. It hands command pulses, counts and the transmit byte to a separate bit engine, and stores the receive byte the engine returns. It does not generate any SCL/SDA timing itself.

The bit engine reports seven kinds of bus event as single-cycle strobes. The block latches each one as a pending flag that stays set until software clears it through a dedicated write-one-to-clear register. Pending flags are gated by per-event masks, a global unmask bit and the controller enable, and the result drives one level-sensitive interrupt line. The engine's bus-busy level is shown live next to the pending flags in the status word. A command readback shows the command the engine is still working on and returns to zero when the engine reports completion or an error.

Top module: `i2cm_regfile`

## Requirements
- R1: After reset every register reads zero, `irq`, `cmd_go` and `ctl_en` are low, and the count, transmit and command outputs are zero.
- R2: The control word at byte offset 0x00 holds the enable in bit 8 and the global unmask in bit 7. Bits 6..0 are per-event unmasks: bit 6 start, bit 5 end, bit 4 send, bit 3 receive, bit 2 missing acknowledge, bit 1 arbitration lost, bit 0 operation complete. It reads back as written, `ctl_en` follows bit 8, and writing zero turns the controller off.
- R3: The status word at 0x0C shows the engine's `eng_busy` level in bit 7 in the same cycle, and the pending flags in bits 6..0 in the event order of R2.
- R4: A strobe on bit i of `eng_evt` sets pending flag i on the next clock edge. The flag stays set until it is cleared, and no flag sets without its strobe.
- R5: A write to 0x08 clears each pending flag whose data bit 6..0 is 1 and leaves the rest alone. Bit 7 is ignored, so writing back a status value just read clears exactly the flags it showed. Offset 0x08 reads zero.
- R6: When a strobe and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: `irq` is registered. It is high in the cycle after one in which the enable, the global unmask and at least one pending flag with its unmask bit set are all present, and low otherwise. Clearing the global unmask keeps the per-event unmask bits unchanged in the readback.
- R8: A write to 0x04 with the enable set and a nonzero field 4..0 produces a one-cycle `cmd_go` on the next edge, with `cmd_bits` equal to that field. The field bits are: bit 4 no-acknowledge, bit 3 start, bit 2 read, bit 1 write, bit 0 stop. Any combination, such as start with write, is accepted.
- R9: Offset 0x04 reads the held command until an operation-complete, arbitration-lost or missing-acknowledge strobe arrives, then reads zero. A new command written in that same cycle is kept.
- R10: A command write while the enable is clear, or with a zero field, gives no `cmd_go` and leaves the command readback unchanged.
- R11: Offsets 0x10 and 0x14 hold the SCL high and low counts (`CNT_W` bits). They read back as written and drive `scl_hi_cnt` and `scl_lo_cnt`.
- R12: The transmit byte at 0x18 drives `tx_byte` and keeps its value until it is rewritten. The receive byte at 0x1C is loaded only by `eng_rx_wr`, and bus writes to it are ignored.
- R13: Addresses with any bit above bit 4 set read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address; bits 1..0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| eng_evt | input | 7 | Single-cycle event strobes from the bit engine |
| eng_busy | input | 1 | Bus-busy level from the bit engine |
| eng_rx_wr | input | 1 | Receive byte load strobe |
| eng_rx_byte | input | BYTE_W | Received byte |
| ctl_en | output | 1 | Controller enable |
| cmd_go | output | 1 | One-cycle command pulse |
| cmd_bits | output | 5 | Held command field |
| scl_hi_cnt | output | CNT_W | SCL high period count |
| scl_lo_cnt | output | CNT_W | SCL low period count |
| tx_byte | output | BYTE_W | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench targets the collision of an event strobe with a clear write to the same flag. A design that lets the clear win would silently lose an event, and the following status read would show the flag at zero. It also writes a status value back into the clear register while the bus is busy, which catches a design that clears unrelated flags or trips over bit 7. Command writes made while the controller is disabled must give no pulse. A command written in the cycle the engine signals completion must survive in the readback, since a design that lets completion win would report the controller idle with a command outstanding. Masking through the global bit alone must drop the interrupt yet keep the per-event bits readable.

// File: rtl/i2cm_regs_pkg.sv
package i2cm_regs_pkg;

    localparam int NUM_EVT   = 7;
    localparam int CMD_W     = 5;
    localparam int EN_BIT    = 8;
    localparam int GU_BIT    = 7;
    localparam int BUSY_BIT  = 7;

    // events that finish the command in flight: op complete, arb lost, no ack
    localparam logic [NUM_EVT-1:0] FINISH_EVTS = 7'b000_0111;

    typedef enum logic [2:0] {
        SEL_CTL  = 3'd0,
        SEL_CMD  = 3'd1,
        SEL_CLR  = 3'd2,
        SEL_STAT = 3'd3,
        SEL_HCNT = 3'd4,
        SEL_LCNT = 3'd5,
        SEL_TX   = 3'd6,
        SEL_RX   = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/i2cm_evt_flags.sv
module i2cm_evt_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_mask_i,
    input  logic [N-1:0] unmask_i,
    input  logic         en_i,
    input  logic         gu_i,
    output logic [N-1:0] pend_o,
    output logic         irq_o
);

    typedef struct packed {
        logic [N-1:0] pend;
        logic         irq;
    } flag_st_t;

    flag_st_t st_d, st_q;
    logic [N-1:0] clr_eff;

    always_comb begin
        st_d    = st_q;
        clr_eff = clr_we_i ? clr_mask_i : '0;
        for (int i = 0; i < N; i++) begin
            // a strobe outranks a clear of the same flag
            st_d.pend[i] = evt_i[i] | (st_q.pend[i] & ~clr_eff[i]);
        end
        st_d.irq = en_i & gu_i & (|(st_q.pend & unmask_i));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_i) |=> ((pend_o & $past(evt_i)) == $past(evt_i))); // R6
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && |(clr_mask_i & ~evt_i)) |=> ((pend_o & $past(clr_mask_i & ~evt_i)) == '0)); // R5
    AST_NO_STRAY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i == '0) |=> ((pend_o & ~$past(pend_o)) == '0)); // R4
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(en_i && gu_i)); // R7

endmodule

// File: rtl/i2cm_cmd_ctl.sv
module i2cm_cmd_ctl #(
    parameter int                W         = 5,
    parameter int                N         = 7,
    parameter logic [N-1:0]      DONE_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         en_i,
    input  logic [N-1:0] evt_i,
    output logic [W-1:0] cmd_o,
    output logic         go_o
);

    typedef struct packed {
        logic [W-1:0] cmd;
        logic         go;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    accept;
    logic    finish;

    always_comb begin
        st_d    = st_q;
        accept  = wr_i & en_i & (|wdata_i);
        finish  = |(evt_i & DONE_MASK);
        st_d.go = 1'b0;
        if (finish) st_d.cmd = '0;
        if (accept) begin
            st_d.cmd = wdata_i;
            st_d.go  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_o = st_q.cmd;
    assign go_o  = st_q.go;

    AST_GO_HAS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> (cmd_o != '0)); // R8
    AST_NO_GO_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> $past(wr_i && en_i)); // R10
    AST_CMD_RETIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt_i & DONE_MASK) && !wr_i) |=> (cmd_o == '0)); // R9

endmodule

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
    import i2cm_regs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_EVT-1:0]  eng_evt,
    input  logic                eng_busy,
    input  logic                eng_rx_wr,
    input  logic [BYTE_W-1:0]   eng_rx_byte,
    output logic                ctl_en,
    output logic                cmd_go,
    output logic [CMD_W-1:0]    cmd_bits,
    output logic [CNT_W-1:0]    scl_hi_cnt,
    output logic [CNT_W-1:0]    scl_lo_cnt,
    output logic [BYTE_W-1:0]   tx_byte,
    output logic                irq
);

    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + 2;

    typedef struct packed {
        logic               en;
        logic               gu;
        logic [NUM_EVT-1:0] unmask;
        logic [CNT_W-1:0]   hcnt;
        logic [CNT_W-1:0]   lcnt;
        logic [BYTE_W-1:0]  tx;
        logic [BYTE_W-1:0]  rx;
    } regs_t;

    regs_t               regs_d, regs_q;
    reg_sel_e            sel;
    logic                mapped;
    logic                wr_hit;
    logic [NUM_EVT-1:0]  pend;

    assign sel = reg_sel_e'(bus_addr[IDX_HI:IDX_LO]);

    generate
        if (ADDR_W > IDX_HI + 1) begin : g_upper_decode
            assign mapped = (bus_addr[ADDR_W-1:IDX_HI+1] == '0);
        end else begin : g_full_decode
            assign mapped = 1'b1;
        end
    endgenerate

    assign wr_hit = bus_wr & mapped;

    always_comb begin
        regs_d = regs_q;
        if (wr_hit) begin
            case (sel)
                SEL_CTL: begin
                    regs_d.en     = bus_wdata[EN_BIT];
                    regs_d.gu     = bus_wdata[GU_BIT];
                    regs_d.unmask = bus_wdata[NUM_EVT-1:0];
                end
                SEL_HCNT: regs_d.hcnt = bus_wdata[CNT_W-1:0];
                SEL_LCNT: regs_d.lcnt = bus_wdata[CNT_W-1:0];
                SEL_TX:   regs_d.tx   = bus_wdata[BYTE_W-1:0];
                default:  ;
            endcase
        end
        if (eng_rx_wr) regs_d.rx = eng_rx_byte;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    i2cm_evt_flags #(
        .N (NUM_EVT)
    ) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (eng_evt),
        .clr_we_i   (wr_hit && sel == SEL_CLR),
        .clr_mask_i (bus_wdata[NUM_EVT-1:0]),
        .unmask_i   (regs_q.unmask),
        .en_i       (regs_q.en),
        .gu_i       (regs_q.gu),
        .pend_o     (pend),
        .irq_o      (irq)
    );

    i2cm_cmd_ctl #(
        .W         (CMD_W),
        .N         (NUM_EVT),
        .DONE_MASK (FINISH_EVTS)
    ) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_hit && sel == SEL_CMD),
        .wdata_i (bus_wdata[CMD_W-1:0]),
        .en_i    (regs_q.en),
        .evt_i   (eng_evt),
        .cmd_o   (cmd_bits),
        .go_o    (cmd_go)
    );

    always_comb begin
        bus_rdata = '0;
        if (mapped) begin
            case (sel)
                SEL_CTL: begin
                    bus_rdata[EN_BIT]        = regs_q.en;
                    bus_rdata[GU_BIT]        = regs_q.gu;
                    bus_rdata[NUM_EVT-1:0]   = regs_q.unmask;
                end
                SEL_CMD:  bus_rdata = 32'(cmd_bits);
                SEL_STAT: begin
                    bus_rdata[BUSY_BIT]      = eng_busy;
                    bus_rdata[NUM_EVT-1:0]   = pend;
                end
                SEL_HCNT: bus_rdata = 32'(regs_q.hcnt);
                SEL_LCNT: bus_rdata = 32'(regs_q.lcnt);
                SEL_TX:   bus_rdata = 32'(regs_q.tx);
                SEL_RX:   bus_rdata = 32'(regs_q.rx);
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign ctl_en     = regs_q.en;
    assign scl_hi_cnt = regs_q.hcnt;
    assign scl_lo_cnt = regs_q.lcnt;
    assign tx_byte    = regs_q.tx;

    AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_rx_wr |=> $stable(regs_q.rx)); // R12
    AST_TX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && sel == SEL_TX) |=> $stable(tx_byte)); // R12
    AST_CTL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && sel == SEL_CTL) |=> $stable(ctl_en)); // R2

endmodule

// File: tb/i2cm_regfile_tb_top.sv
module i2cm_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        b_wr;
    logic [5:0]  b_addr;
    logic [31:0] b_wdata;
    logic [31:0] rdata;
    logic [6:0]  b_evt;
    logic        b_busy;
    logic        b_rxw;
    logic [7:0]  b_rxb;
    logic        en_o, go_o, irq_o;
    logic [4:0]  cmd_o;
    logic [15:0] hi_o, lo_o;
    logic [7:0]  tx_o;

    int vecs = 0;
    int errs = 0;

    always #10 clk = ~clk;

    i2cm_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(b_wr), .bus_addr(b_addr),
        .bus_wdata(b_wdata), .bus_rdata(rdata), .eng_evt(b_evt),
        .eng_busy(b_busy), .eng_rx_wr(b_rxw), .eng_rx_byte(b_rxb),
        .ctl_en(en_o), .cmd_go(go_o), .cmd_bits(cmd_o),
        .scl_hi_cnt(hi_o), .scl_lo_cnt(lo_o), .tx_byte(tx_o), .irq(irq_o)
    );

    // behavioural reference
    logic        m_en, m_gu, m_irq, m_go;
    logic [6:0]  m_mask, m_pend;
    logic [4:0]  m_cmd;
    logic [15:0] m_hi, m_lo;
    logic [7:0]  m_tx, m_rx;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_gu = 0; m_irq = 0; m_go = 0; m_mask = 0; m_pend = 0;
            m_cmd = 0; m_hi = 0; m_lo = 0; m_tx = 0; m_rx = 0;
        end else begin
            m_irq = m_en && m_gu && ((m_pend & m_mask) != 0);
            m_go = 0;
            if ((b_evt & 7'h07) != 0) m_cmd = 0;
            if (b_wr && !b_addr[5] && b_addr[4:2] == 3'd1 && m_en && b_wdata[4:0] != 0) begin
                m_cmd = b_wdata[4:0];
                m_go = 1;
            end
            if (b_wr && !b_addr[5] && b_addr[4:2] == 3'd2) m_pend = m_pend & ~b_wdata[6:0];
            m_pend = m_pend | b_evt;
            if (b_wr && !b_addr[5]) begin
                case (b_addr[4:2])
                    3'd0: begin m_en = b_wdata[8]; m_gu = b_wdata[7]; m_mask = b_wdata[6:0]; end
                    3'd4: m_hi = b_wdata[15:0];
                    3'd5: m_lo = b_wdata[15:0];
                    3'd6: m_tx = b_wdata[7:0];
                    default: ;
                endcase
            end
            if (b_rxw) m_rx = b_rxb;
        end
    end

    function automatic logic [31:0] m_read(input logic [5:0] a);
        if (a[5]) return 32'h0;
        case (a[4:2])
            3'd0: return {23'h0, m_en, m_gu, m_mask};
            3'd1: return {27'h0, m_cmd};
            3'd3: return {24'h0, b_busy, m_pend};
            3'd4: return {16'h0, m_hi};
            3'd5: return {16'h0, m_lo};
            3'd6: return {24'h0, m_tx};
            3'd7: return {24'h0, m_rx};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string rd_tag(input logic [5:0] a);
        if (a[5]) return "R13 unmapped read";
        case (a[4:2])
            3'd0: return "R2 control read";
            3'd1: return "R9 command read";
            3'd2: return "R13 clear-offset read";
            3'd3: return "R3 status read";
            3'd4, 3'd5: return "R11 count read";
            default: return "R12 data read";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [5:0] a, input logic [31:0] d,
                        input logic [6:0] e, input logic busy,
                        input logic rxw, input logic [7:0] rxb);
        @(negedge clk);
        b_wr = wr; b_addr = a; b_wdata = d; b_evt = e; b_busy = busy;
        b_rxw = rxw; b_rxb = rxb;
        #1;
        chk("R7 irq", {31'h0, irq_o}, {31'h0, m_irq});
        chk("R8 cmd_go", {31'h0, go_o}, {31'h0, m_go});
        chk("R8 cmd_bits", {27'h0, cmd_o}, {27'h0, m_cmd});
        chk("R2 ctl_en", {31'h0, en_o}, {31'h0, m_en});
        chk("R11 scl counts", {hi_o, lo_o}, {m_hi, m_lo});
        chk("R12 tx_byte", {24'h0, tx_o}, {24'h0, m_tx});
        chk(rd_tag(a), rdata, m_read(a));
    endtask

    task automatic rd(input logic [5:0] a);
        step(0, a, 32'h0, 7'h0, b_busy, 0, 8'h0);
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        step(1, a, d, 7'h0, b_busy, 0, 8'h0);
    endtask

    initial begin
        #4_000_000;
        errs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [31:0] snap;
        rst_n = 0; b_wr = 0; b_addr = 0; b_wdata = 0; b_evt = 0; b_busy = 0;
        b_rxw = 0; b_rxb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values on every offset
        for (int i = 0; i < 8; i++) begin
            rd(6'(i * 4));
            chk("R1 reset read", rdata, 32'h0);
        end
        chk("R1 reset irq/go", {30'h0, irq_o, go_o}, 32'h0);

        // R2/R11/R12 setup
        wr(6'h00, 32'h1FF);
        wr(6'h10, 32'h0000_00F9);
        wr(6'h14, 32'h0001_2345);
        wr(6'h18, 32'h0000_1C3A);
        rd(6'h18);
        chk("R12 tx holds", {24'h0, tx_o}, 32'h3A);

        // R4 single event, irq follows (R7)
        step(0, 6'h0C, 0, 7'h01, 0, 0, 0);
        rd(6'h0C);
        chk("R4 flag set", rdata, 32'h01);
        rd(6'h0C);
        chk("R7 irq raised", {31'h0, irq_o}, 32'h1);

        // R5 write back of a status snapshot while busy
        step(0, 6'h0C, 0, 7'h54, 1, 0, 0);
        rd(6'h0C);
        snap = rdata;
        chk("R3 busy and flags", snap, 32'hD5);
        wr(6'h08, snap);
        rd(6'h0C);
        chk("R5 writeback clears", rdata, 32'h80);

        // R6 strobe and clear on the same flag
        step(0, 6'h0C, 0, 7'h03, 0, 0, 0);
        step(1, 6'h08, 32'h7F, 7'h04, 0, 0, 0);
        rd(6'h0C);
        chk("R6 set beats clear", rdata, 32'h04);
        wr(6'h08, 32'h40);
        rd(6'h0C);
        chk("R5 unrelated kept", rdata, 32'h04);

        // R7 global unmask off keeps per-event unmask bits
        wr(6'h00, 32'h17F);
        rd(6'h00);
        rd(6'h00);
        chk("R7 irq masked globally", {31'h0, irq_o}, 32'h0);
        chk("R7 unmask retained", rdata, 32'h17F);
        wr(6'h00, 32'h1FB);
        wr(6'h08, 32'h7F);

        // R8 / R9 commands
        wr(6'h04, 32'h0A);
        rd(6'h04);
        chk("R8 start+write pulse", {26'h0, go_o, cmd_o}, {26'h0, 1'b1, 5'h0A});
        rd(6'h04);
        chk("R8 pulse one cycle", {31'h0, go_o}, 32'h0);
        step(0, 6'h04, 0, 7'h01, 1, 0, 0);
        rd(6'h04);
        chk("R9 retired by done", rdata, 32'h0);
        wr(6'h04, 32'h04);
        step(1, 6'h04, 32'h14, 7'h04, 1, 0, 0);
        rd(6'h04);
        chk("R9 new write wins", rdata, 32'h14);
        step(0, 6'h04, 0, 7'h02, 0, 1, 8'hA5);
        wr(6'h04, 32'h01);
        step(0, 6'h04, 0, 7'h01, 0, 0, 0);

        // R10 zero field and disabled controller
        wr(6'h04, 32'h20);
        rd(6'h04);
        chk("R10 zero field", {26'h0, go_o, cmd_o}, 32'h0);
        wr(6'h00, 32'h0);
        wr(6'h04, 32'h08);
        rd(6'h04);
        chk("R10 disabled command", {26'h0, go_o, cmd_o}, 32'h0);

        // R12 receive byte, R13 unmapped
        wr(6'h1C, 32'h77);
        rd(6'h1C);
        chk("R12 rx ignores bus", rdata, 32'hA5);
        wr(6'h20, 32'h1FF);
        rd(6'h20);
        chk("R13 unmapped read", rdata, 32'h0);
        rd(6'h00);
        chk("R13 unmapped write", rdata, 32'h0);

        // mixed traffic against the model
        wr(6'h00, 32'h1FF);
        for (int k = 0; k < 600; k++) begin
            logic [5:0] a;
            logic [31:0] d;
            logic [6:0] e;
            a = 6'($urandom_range(0, 8) * 4);
            d = $urandom;
            if (a == 6'h00 && ($urandom % 4) != 0) d[8] = 1'b1;
            e = (($urandom % 3) == 0) ? 7'($urandom) : 7'h0;
            step(($urandom % 2) == 0, a, d, e, 1'($urandom), ($urandom % 5) == 0, 8'($urandom));
        end
        rd(6'h00);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

endmodule